// File: doc/BRIEF.md
# Multi-Hash Signature Table Loader

This block builds the lookup tables that a streaming string matcher walks. Software splits each attack signature into fixed-length substrings, usually five bytes, with a shorter last one. It then presents the substrings in order. For each substring the block stores the key, a link to the slot of the previous substring, head and tail markers and a signature tag. The entry goes into the table block that belongs to the substring's position in its signature. Each position block holds two hash tables, and each table has two identical copies. A substring has four candidate slots: the first-hash index in both copies and the second-hash index in both copies.

An insert is one valid/ready request. The block hashes the key, reads all four candidate slots of the chosen position block at once and decides in one cycle. If a candidate already holds the same key with the same parent link, the block returns that slot and writes nothing, so common signature prefixes share storage. Otherwise it fills the first empty candidate. If all four candidates are occupied by other entries, it reports an overflow. The response carries the slot address, which the caller passes as the parent link of the next substring. A separate read port lets the matcher, or a check, fetch any stored slot.

The controller has three states:
- `ST_IDLE` accepts a request.
- `ST_PROBE` decides and writes.
- `ST_REPLY` presents the response.

The transitions are:
- ST_IDLE to ST_PROBE on an accepted request.
- ST_PROBE to ST_REPLY unconditionally.
- ST_REPLY to ST_IDLE unconditionally.

Top module: `sigtab_loader`

## Requirements
- R1: After reset `in_ready` is 1, `rsp_valid` is 0 and every slot reads back with `rd_hit` = 0.
- R2: A request is taken in a cycle where `in_valid` and `in_ready` are both 1. `in_ready` is then 0 until the response has been given. `rsp_valid` is 1 for exactly one cycle, two cycles after the accepting cycle. `in_ready` is 1 again in the next cycle.
- R3: First hash: key bit i (of 40) is XORed into index bit (i mod 9). Its candidates are addresses {0, copy, index}.
- R4: Second hash: each key byte b is rotated left by (b mod 8) bits, so bit j of byte b moves to bit 8b+((j+b) mod 8). The result is XOR-folded the same way. Its candidates are addresses {1, copy, index}.
- R5: The slot address is 11 bits: bit 10 is the hash select, bit 9 is the copy and bits 8:0 are the index. A new entry takes the first empty candidate in this order: hash 1 copy 0, hash 1 copy 1, hash 2 copy 0, hash 2 copy 1. In that case `rsp_reused` is 0 and `rsp_err` is 0.
- R6: If an occupied candidate holds the same key and the same parent link, the response gives that slot with `rsp_reused` = 1 and nothing is written. The lowest candidate in the R5 order wins.
- R7: A candidate whose key matches but whose parent link differs is not reused.
- R8: If all four candidates are occupied and none matches, the response has `rsp_err` = 1, `rsp_reused` = 0 and address 0. No slot changes.
- R9: `in_pos` (2 bits) selects one of four independent position blocks. Equal keys at different positions do not interact.
- R10: The read port returns the slot at `rd_addr` in block `rd_pos` one cycle later. It gives the occupancy on `rd_hit`, plus the key, parent link, head flag, tail flag and tag.
- R11: A newly written slot holds the request's key, parent link, head flag, tail flag and tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears occupancy |
| in_valid | input | 1 | Insert request present |
| in_ready | output | 1 | Block can take a request |
| in_key | input | 40 | Substring, zero-padded above its length |
| in_pos | input | 2 | Position of the substring in its signature |
| in_head | input | 1 | First substring of a signature |
| in_tail | input | 1 | Last substring of a signature |
| in_parent | input | 11 | Slot address of the previous substring |
| in_sig | input | 8 | Signature tag |
| rsp_valid | output | 1 | Response present |
| rsp_addr | output | 11 | Chosen slot address |
| rsp_reused | output | 1 | Existing slot returned |
| rsp_err | output | 1 | All candidates occupied |
| rd_pos | input | 2 | Read port block select |
| rd_addr | input | 11 | Read port slot address |
| rd_hit | output | 1 | Read slot is occupied |
| rd_key | output | 40 | Read slot key |
| rd_parent | output | 11 | Read slot parent link |
| rd_head | output | 1 | Read slot head flag |
| rd_tail | output | 1 | Read slot tail flag |
| rd_sig | output | 8 | Read slot tag |

## Verification
The properties assume that request fields matter only in the cycle a request is accepted. They also assume that a caller never relies on `in_ready` staying high after an accept. The bench drives fields only together with `in_valid`, and drops `in_valid` right after the accepting edge.

Keys are assumed to carry zeros above a short substring. The bench therefore uses full or zero-padded keys only. It chooses the colliding keys by XORing patterns that cancel in both hash functions, which guarantees four keys that share all four candidate slots.

// File: rtl/sigtab_pkg.sv
package sigtab_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_PROBE = 2'd1,
        ST_REPLY = 2'd2
    } ld_state_e;

endpackage

// File: rtl/sigtab_hash.sv
module sigtab_hash #(
    parameter  int KEY_W = 40,
    parameter  int IDX_W = 9,
    localparam int NBYTE = KEY_W / 8,
    localparam int NCH   = (KEY_W + IDX_W - 1) / IDX_W
) (
    input  logic [KEY_W-1:0] key,
    output logic [IDX_W-1:0] idx_a,
    output logic [IDX_W-1:0] idx_b
);

    logic [KEY_W-1:0]       rot;
    logic [NCH*IDX_W-1:0]   pad_a;
    logic [NCH*IDX_W-1:0]   pad_b;

    // each byte rotated left by its byte number
    for (genvar b = 0; b < NBYTE; b++) begin : g_rot
        localparam int R = b % 8;
        logic [15:0] dbl;
        assign dbl            = {key[b*8 +: 8], key[b*8 +: 8]};
        assign rot[b*8 +: 8]  = dbl[15-R -: 8];
    end

    assign pad_a = (NCH*IDX_W)'(key);
    assign pad_b = (NCH*IDX_W)'(rot);

    always_comb begin
        idx_a = '0;
        idx_b = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            idx_a = idx_a ^ pad_a[ch*IDX_W +: IDX_W];
            idx_b = idx_b ^ pad_b[ch*IDX_W +: IDX_W];
        end
    end

endmodule

// File: rtl/sigtab_bank.sv
module sigtab_bank #(
    parameter  int KEY_W  = 40,
    parameter  int IDX_W  = 9,
    parameter  int SEL_W  = 2,
    parameter  int SIG_W  = 8,
    localparam int ADDR_W = SEL_W + IDX_W,
    localparam int NCAND  = 1 << SEL_W,
    localparam int DEPTH  = 1 << ADDR_W,
    localparam int ENT_W  = KEY_W + ADDR_W + 2 + SIG_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IDX_W-1:0]              idx_a,
    input  logic [IDX_W-1:0]              idx_b,
    output logic [NCAND-1:0]              cand_vld,
    output logic [NCAND-1:0][KEY_W-1:0]   cand_key,
    output logic [NCAND-1:0][ADDR_W-1:0]  cand_par,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [ENT_W-1:0]              wr_ent,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic                          rd_vld,
    output logic [ENT_W-1:0]              rd_ent
);

    logic [ENT_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0] occ;

    // upper half of the candidates use the second hash
    for (genvar c = 0; c < NCAND; c++) begin : g_cand
        logic [ADDR_W-1:0] a_c;
        assign a_c         = {SEL_W'(c), (c >= NCAND/2) ? idx_b : idx_a};
        assign cand_vld[c] = occ[a_c];
        assign cand_key[c] = mem[a_c][ENT_W-1 -: KEY_W];
        assign cand_par[c] = mem[a_c][ENT_W-KEY_W-1 -: ADDR_W];
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem[wr_addr] <= wr_ent;
        end
        rd_ent <= mem[rd_addr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            occ    <= '0;
            rd_vld <= 1'b0;
        end else begin
            if (wr_en) begin
                occ[wr_addr] <= 1'b1;
            end
            rd_vld <= occ[rd_addr];
        end
    end

endmodule

// File: rtl/sigtab_pick.sv
module sigtab_pick #(
    parameter  int KEY_W  = 40,
    parameter  int SEL_W  = 2,
    parameter  int ADDR_W = 11,
    localparam int NCAND  = 1 << SEL_W
) (
    input  logic [NCAND-1:0]              cand_vld,
    input  logic [NCAND-1:0][KEY_W-1:0]   cand_key,
    input  logic [NCAND-1:0][ADDR_W-1:0]  cand_par,
    input  logic [KEY_W-1:0]              req_key,
    input  logic [ADDR_W-1:0]             req_par,
    output logic                          hit,
    output logic [SEL_W-1:0]              hit_sel,
    output logic                          free,
    output logic [SEL_W-1:0]              free_sel
);

    // walk from the highest candidate down so the lowest one wins
    always_comb begin
        hit      = 1'b0;
        hit_sel  = '0;
        free     = 1'b0;
        free_sel = '0;
        for (int c = NCAND - 1; c >= 0; c--) begin
            if (cand_vld[c] && cand_key[c] == req_key && cand_par[c] == req_par) begin
                hit     = 1'b1;
                hit_sel = SEL_W'(c);
            end
            if (!cand_vld[c]) begin
                free     = 1'b1;
                free_sel = SEL_W'(c);
            end
        end
    end

endmodule

// File: rtl/sigtab_loader.sv
module sigtab_loader
    import sigtab_pkg::*;
#(
    parameter  int KEY_BYTES  = 5,
    parameter  int IDX_W      = 9,
    parameter  int COPIES     = 2,
    parameter  int POS_BLOCKS = 4,
    parameter  int SIG_W      = 8,
    localparam int KEY_W      = 8 * KEY_BYTES,
    localparam int CP_W       = $clog2(COPIES),
    localparam int SEL_W      = CP_W + 1,
    localparam int NCAND      = 1 << SEL_W,
    localparam int ADDR_W     = SEL_W + IDX_W,
    localparam int POS_W      = $clog2(POS_BLOCKS),
    localparam int ENT_W      = KEY_W + ADDR_W + 2 + SIG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [KEY_W-1:0]  in_key,
    input  logic [POS_W-1:0]  in_pos,
    input  logic              in_head,
    input  logic              in_tail,
    input  logic [ADDR_W-1:0] in_parent,
    input  logic [SIG_W-1:0]  in_sig,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_reused,
    output logic              rsp_err,
    input  logic [POS_W-1:0]  rd_pos,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic              rd_hit,
    output logic [KEY_W-1:0]  rd_key,
    output logic [ADDR_W-1:0] rd_parent,
    output logic              rd_head,
    output logic              rd_tail,
    output logic [SIG_W-1:0]  rd_sig
);

    ld_state_e state, state_nx;

    logic [KEY_W-1:0]  key_q;
    logic [POS_W-1:0]  pos_q;
    logic              head_q, tail_q;
    logic [ADDR_W-1:0] par_q;
    logic [SIG_W-1:0]  sig_q;
    logic [ADDR_W-1:0] addr_q;
    logic              reused_q, err_q;
    logic [POS_W-1:0]  rd_pos_q;

    logic [IDX_W-1:0]  idx_a, idx_b;
    logic              hit, free;
    logic [SEL_W-1:0]  hit_sel, free_sel;
    logic [ADDR_W-1:0] hit_addr, free_addr;
    logic              wr_fire;
    logic [ENT_W-1:0]  wr_ent;
    logic [ENT_W-1:0]  rd_ent;

    logic [POS_BLOCKS-1:0][NCAND-1:0]             bk_vld;
    logic [POS_BLOCKS-1:0][NCAND-1:0][KEY_W-1:0]  bk_key;
    logic [POS_BLOCKS-1:0][NCAND-1:0][ADDR_W-1:0] bk_par;
    logic [POS_BLOCKS-1:0]                        bk_rd_vld;
    logic [POS_BLOCKS-1:0][ENT_W-1:0]             bk_rd_ent;

    sigtab_hash #(.KEY_W(KEY_W), .IDX_W(IDX_W)) u_hash (
        .key   (key_q),
        .idx_a (idx_a),
        .idx_b (idx_b)
    );

    assign wr_ent = {key_q, par_q, head_q, tail_q, sig_q};

    for (genvar b = 0; b < POS_BLOCKS; b++) begin : g_blk
        sigtab_bank #(
            .KEY_W (KEY_W),
            .IDX_W (IDX_W),
            .SEL_W (SEL_W),
            .SIG_W (SIG_W)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .idx_a    (idx_a),
            .idx_b    (idx_b),
            .cand_vld (bk_vld[b]),
            .cand_key (bk_key[b]),
            .cand_par (bk_par[b]),
            .wr_en    (wr_fire && (pos_q == POS_W'(b))),
            .wr_addr  (free_addr),
            .wr_ent   (wr_ent),
            .rd_addr  (rd_addr),
            .rd_vld   (bk_rd_vld[b]),
            .rd_ent   (bk_rd_ent[b])
        );
    end

    sigtab_pick #(.KEY_W(KEY_W), .SEL_W(SEL_W), .ADDR_W(ADDR_W)) u_pick (
        .cand_vld (bk_vld[pos_q]),
        .cand_key (bk_key[pos_q]),
        .cand_par (bk_par[pos_q]),
        .req_key  (key_q),
        .req_par  (par_q),
        .hit      (hit),
        .hit_sel  (hit_sel),
        .free     (free),
        .free_sel (free_sel)
    );

    assign hit_addr  = {hit_sel,  hit_sel[SEL_W-1]  ? idx_b : idx_a};
    assign free_addr = {free_sel, free_sel[SEL_W-1] ? idx_b : idx_a};
    assign wr_fire   = (state == ST_PROBE) && !hit && free;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (in_valid) state_nx = ST_PROBE;
            ST_PROBE: state_nx = ST_REPLY;
            ST_REPLY: state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // request capture and decision registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_q    <= '0;
            pos_q    <= '0;
            head_q   <= 1'b0;
            tail_q   <= 1'b0;
            par_q    <= '0;
            sig_q    <= '0;
            addr_q   <= '0;
            reused_q <= 1'b0;
            err_q    <= 1'b0;
            rd_pos_q <= '0;
        end else begin
            rd_pos_q <= rd_pos;
            if (state == ST_IDLE && in_valid) begin
                key_q  <= in_key;
                pos_q  <= in_pos;
                head_q <= in_head;
                tail_q <= in_tail;
                par_q  <= in_parent;
                sig_q  <= in_sig;
            end
            if (state == ST_PROBE) begin
                addr_q   <= hit ? hit_addr : (free ? free_addr : '0);
                reused_q <= hit;
                err_q    <= !hit && !free;
            end
        end
    end

    // outputs
    always_comb begin
        in_ready   = (state == ST_IDLE);
        rsp_valid  = (state == ST_REPLY);
        rsp_addr   = addr_q;
        rsp_reused = rsp_valid && reused_q;
        rsp_err    = rsp_valid && err_q;
        rd_ent     = bk_rd_ent[rd_pos_q];
        rd_hit     = bk_rd_vld[rd_pos_q];
        rd_key     = rd_ent[ENT_W-1 -: KEY_W];
        rd_parent  = rd_ent[ENT_W-KEY_W-1 -: ADDR_W];
        rd_head    = rd_ent[SIG_W+1];
        rd_tail    = rd_ent[SIG_W];
        rd_sig     = rd_ent[SIG_W-1:0];
    end

endmodule

// File: rtl/sigtab_loader_chk.sv
module sigtab_loader_chk #(
    parameter int ADDR_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_ready,
    input logic              rsp_valid,
    input logic [ADDR_W-1:0] rsp_addr,
    input logic              rsp_reused,
    input logic              rsp_err
);

    AST_RSP_TWO_LATER: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |-> ##2 rsp_valid);                         // R2
    AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready |=> !in_ready);                             // R2
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);                                       // R2
    AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> in_ready);                                         // R2
    AST_FLAGS_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_valid |-> !rsp_err && !rsp_reused);                         // R8
    AST_ERR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> !rsp_reused && rsp_addr == '0);                      // R8

endmodule

bind sigtab_loader sigtab_loader_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .rsp_valid  (rsp_valid),
    .rsp_addr   (rsp_addr),
    .rsp_reused (rsp_reused),
    .rsp_err    (rsp_err)
);

// File: tb/sigtab_loader_bench.sv
module sigtab_loader_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [39:0] in_key = '0;
    logic [1:0]  in_pos = '0;
    logic        in_head = 1'b0;
    logic        in_tail = 1'b0;
    logic [10:0] in_parent = '0;
    logic [7:0]  in_sig = '0;
    logic        rsp_valid;
    logic [10:0] rsp_addr;
    logic        rsp_reused;
    logic        rsp_err;
    logic [1:0]  rd_pos = '0;
    logic [10:0] rd_addr = '0;
    logic        rd_hit;
    logic [39:0] rd_key;
    logic [10:0] rd_parent;
    logic        rd_head;
    logic        rd_tail;
    logic [7:0]  rd_sig;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    sigtab_loader u_sigtab_loader (
        .clk, .rst_n, .in_valid, .in_ready, .in_key, .in_pos, .in_head,
        .in_tail, .in_parent, .in_sig, .rsp_valid, .rsp_addr, .rsp_reused,
        .rsp_err, .rd_pos, .rd_addr, .rd_hit, .rd_key, .rd_parent,
        .rd_head, .rd_tail, .rd_sig
    );

    function automatic logic [8:0] fh1(input logic [39:0] k);
        logic [8:0] r = '0;
        for (int i = 0; i < 40; i++)
            r = r ^ (9'((k >> i) & 40'd1) << (i % 9));
        return r;
    endfunction

    function automatic logic [8:0] fh2(input logic [39:0] k);
        logic [8:0] r = '0;
        for (int i = 0; i < 40; i++) begin
            int p = 8 * (i / 8) + ((i % 8 + i / 8) % 8);
            r = r ^ (9'((k >> i) & 40'd1) << (p % 9));
        end
        return r;
    endfunction

    task automatic check(input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic ins(input logic [39:0] k, input logic [1:0] p, input logic h,
                       input logic t, input logic [10:0] par, input logic [7:0] s,
                       output logic [10:0] a, output logic ru, output logic er);
        @(negedge clk);
        check("R2", "ready before accept", in_ready, 1);
        in_valid = 1'b1; in_key = k; in_pos = p; in_head = h;
        in_tail = t; in_parent = par; in_sig = s;
        @(negedge clk);
        in_valid = 1'b0;
        check("R2", "busy after accept", {in_ready, rsp_valid}, 2'b00);
        @(negedge clk);
        check("R2", "response after two", rsp_valid, 1);
        a = rsp_addr; ru = rsp_reused; er = rsp_err;
        @(negedge clk);
        check("R2", "pulse and ready", {rsp_valid, in_ready}, 2'b01);
    endtask

    task automatic expect_ins(input string req, input logic [39:0] k,
                              input logic [1:0] p, input logic h, input logic t,
                              input logic [10:0] par, input logic [7:0] s,
                              input logic [10:0] ea, input logic eru, input logic eer);
        logic [10:0] a;
        logic ru, er;
        ins(k, p, h, t, par, s, a, ru, er);
        check(req, "addr", a, ea);
        check(req, "reused", ru, eru);
        check(req, "err", er, eer);
    endtask

    task automatic rd(input logic [1:0] p, input logic [10:0] a);
        @(negedge clk);
        rd_pos = p; rd_addr = a;
        @(negedge clk);
    endtask

    localparam logic [39:0] KA = 40'h11_2233_4455;
    localparam logic [39:0] KB = 40'h3C_5A00_0000;
    localparam logic [39:0] D1 = 40'h00_0004_0602;
    localparam logic [39:0] D2 = 40'h00_0008_0C04;
    localparam logic [39:0] D3 = 40'h00_0010_1808;

    task automatic t_reset();
        check("R1", "ready", in_ready, 1);
        check("R1", "rsp_valid", rsp_valid, 0);
        rd(2'd0, 11'd0);
        check("R1", "empty slot", rd_hit, 0);
        rd(2'd3, 11'h7FF);
        check("R1", "empty slot high", rd_hit, 0);
    endtask

    task automatic t_basic();
        logic [8:0] ha = fh1(KA);
        expect_ins("R3", KA, 2'd0, 1'b1, 1'b0, 11'd0, 8'h21, {2'b00, ha}, 1'b0, 1'b0);
        rd(2'd0, {2'b00, ha});
        check("R11", "occupied", rd_hit, 1);
        check("R11", "key", rd_key, KA);
        check("R11", "parent", rd_parent, 0);
        check("R11", "flags", {rd_head, rd_tail}, 2'b10);
        check("R10", "tag", rd_sig, 8'h21);
    endtask

    task automatic t_reuse();
        logic [8:0] ha = fh1(KA);
        expect_ins("R6", KA, 2'd0, 1'b1, 1'b0, 11'd0, 8'h21, {2'b00, ha}, 1'b1, 1'b0);
        rd(2'd0, {2'b01, ha});
        check("R6", "no write on reuse", rd_hit, 0);
        expect_ins("R7", KA, 2'd0, 1'b0, 1'b0, 11'd5, 8'h22, {2'b01, ha}, 1'b0, 1'b0);
    endtask

    task automatic t_position();
        logic [8:0] ha = fh1(KA);
        expect_ins("R9", KA, 2'd2, 1'b0, 1'b0, 11'd0, 8'h30, {2'b00, ha}, 1'b0, 1'b0);
        rd(2'd1, {2'b00, ha});
        check("R9", "other block untouched", rd_hit, 0);
    endtask

    task automatic t_fallback();
        logic [8:0]  ha = fh1(KA);
        logic [39:0] kc = KA ^ 40'h201;
        logic [39:0] kd = KA ^ 40'h4_0001;
        logic [39:0] ke = KA ^ 40'h800_0001;
        logic [10:0] pa = {2'b00, ha};
        expect_ins("R5", KA, 2'd1, 1'b0, 1'b0, pa, 8'h40, {2'b00, ha}, 1'b0, 1'b0);
        expect_ins("R5", kc, 2'd1, 1'b0, 1'b0, pa, 8'h41, {2'b01, ha}, 1'b0, 1'b0);
        expect_ins("R4", kd, 2'd1, 1'b0, 1'b0, pa, 8'h42, {2'b10, fh2(kd)}, 1'b0, 1'b0);
        expect_ins("R4", ke, 2'd1, 1'b0, 1'b0, pa, 8'h43,
                   {(fh2(ke) == fh2(kd)) ? 2'b11 : 2'b10, fh2(ke)}, 1'b0, 1'b0);
        rd(2'd1, {2'b10, fh2(kd)});
        check("R4", "second hash key", rd_key, kd);
    endtask

    task automatic t_overflow();
        logic [8:0]  t = fh1(KB);
        logic [8:0]  u = fh2(KB);
        logic [10:0] pp = 11'h123;
        expect_ins("R5", KB,            2'd3, 1'b0, 1'b0, pp, 8'h70, {2'b00, t}, 1'b0, 1'b0);
        expect_ins("R5", KB ^ D1,       2'd3, 1'b0, 1'b0, pp, 8'h71, {2'b01, t}, 1'b0, 1'b0);
        expect_ins("R5", KB ^ D2,       2'd3, 1'b0, 1'b0, pp, 8'h72, {2'b10, u}, 1'b0, 1'b0);
        expect_ins("R5", KB ^ D3,       2'd3, 1'b0, 1'b1, pp, 8'h77, {2'b11, u}, 1'b0, 1'b0);
        expect_ins("R8", KB ^ D1 ^ D2,  2'd3, 1'b0, 1'b0, pp, 8'h78, 11'd0, 1'b0, 1'b1);
        expect_ins("R8", KB ^ D1 ^ D2,  2'd3, 1'b0, 1'b0, pp, 8'h78, 11'd0, 1'b0, 1'b1);
        expect_ins("R6", KB ^ D2,       2'd3, 1'b0, 1'b0, pp, 8'h72, {2'b10, u}, 1'b1, 1'b0);
        expect_ins("R7", KB, 2'd3, 1'b0, 1'b0, 11'h124, 8'h79, 11'd0, 1'b0, 1'b1);
        rd(2'd3, {2'b11, u});
        check("R8", "slot kept key", rd_key, KB ^ D3);
        check("R11", "tail and tag", {rd_head, rd_tail, rd_sig}, {2'b01, 8'h77});
        check("R10", "parent", rd_parent, pp);
        rd(2'd3, {2'b00, t});
        check("R8", "first slot kept", rd_key, KB);
        check("R10", "first slot tag", rd_sig, 8'h70);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_reuse();
        t_position();
        t_fallback();
        t_overflow();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL R2 watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule